// File: doc/BRIEF.md
# 64-bit Free-Running Timer with Auto-Rearming Comparator

The block keeps a 64-bit up-counter that advances by one on every clock-enable pulse while its run bit is set. A 64-bit comparator watches the count. When the comparator is enabled and the count equals it, an interrupt flag sets. With auto-rearm turned on, the comparator steps forward by a programmable 32-bit increment after each match, so the block raises a periodic event without software help.

Software reaches the block over a plain 32-bit register bus. Reads are combinational from the address. A write to either counter half, either comparator half, the increment or the control register does not take effect at once. The value travels through a fixed-latency apply stage, and a per-register confirmation flag sets in the same cycle that the value lands. Software clears each confirmation flag, and the interrupt flag, by writing a one to its bit. The counter advances as one 64-bit quantity, so a reader that reads high, then low, then high again and retries on a mismatch never sees a low-word rollover paired with a stale high word.

Top module: `tmr64_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While control bit 8 (run) at offset 0x240 is set, the counter increments by one on each cycle with `tick_en` high. It wraps from all-ones to zero and holds otherwise. Control reads back only bits 8, 1 and 0.
- R3: A write to 0x100 (low half) or 0x104 (high half) replaces that half of the counter exactly APPLY_LAT clock edges after the write edge. In the cycle a counter write lands, the increment is suppressed.
- R4: A carry out of the low half reaches the high half in the same cycle, so both halves read consistently after a low-word rollover.
- R5: Confirmation flags set APPLY_LAT edges after the write and not earlier. Offset 0x110 holds bit 0 for the counter low half and bit 1 for the counter high half. Offset 0x24C holds bit 0 for comparator low (0x200), bit 1 for comparator high (0x204), bit 2 for the increment (0x208) and bit 16 for control. Writing a one to a bit clears it on the next edge. A flag that sets in the same cycle as its clear stays set.
- R6: When control bit 0 (compare enable) is set and the counter equals the 64-bit comparator, bit 0 of the status register at 0x244 sets.
- R7: When control bit 1 (auto-rearm) is also set, each match replaces the comparator with its old value plus the zero-extended increment. In the cycle a comparator write lands, the rearm is suppressed.
- R8: `irq` equals status bit 0 ANDed with enable bit 0 at 0x248. Writing one to 0x244 bit 0 clears the status unless a match occurs in the same cycle, in which case the status stays set.
- R9: Reads of unmapped offsets, and of unused bits in mapped registers, return zero.
- R10: With compare enable clear, an equal count and comparator does not set the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| tick_en | input | 1 | Counter advance pulse |
| bus_req | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Comparator interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a confirmation flag that sets in the same cycle software clears it. The other is a match that coincides with a status clear. Both need stimulus placed exactly APPLY_LAT cycles after an earlier write, or a counter parked on the comparator value. The stimulus parks the counter by stopping `tick_en`, then issues a clear three bus cycles after a counter write so that it lands on the apply edge. Auto-rearm is checked by releasing an exact number of ticks from a known preload and reading the comparator back.

// File: rtl/tmr64_pkg.sv
package tmr64_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NREG   = 6;

  // index of each applied register inside the apply payload
  localparam int unsigned R_CLO = 0;
  localparam int unsigned R_CHI = 1;
  localparam int unsigned R_MLO = 2;
  localparam int unsigned R_MHI = 3;
  localparam int unsigned R_INC = 4;
  localparam int unsigned R_CTL = 5;

  localparam logic [ADDR_W-1:0] A_CLO = 12'h100;
  localparam logic [ADDR_W-1:0] A_CHI = 12'h104;
  localparam logic [ADDR_W-1:0] A_CWS = 12'h110;
  localparam logic [ADDR_W-1:0] A_MLO = 12'h200;
  localparam logic [ADDR_W-1:0] A_MHI = 12'h204;
  localparam logic [ADDR_W-1:0] A_INC = 12'h208;
  localparam logic [ADDR_W-1:0] A_CTL = 12'h240;
  localparam logic [ADDR_W-1:0] A_IST = 12'h244;
  localparam logic [ADDR_W-1:0] A_IEN = 12'h248;
  localparam logic [ADDR_W-1:0] A_GWS = 12'h24C;

  localparam int unsigned B_RUN    = 8;
  localparam int unsigned B_AUTO   = 1;
  localparam int unsigned B_CMPEN  = 0;
  localparam int unsigned B_WS_CTL = 16;

  typedef struct packed {
    logic run;
    logic autoinc;
    logic cmp_en;
  } ctl_t;

  function automatic logic [ADDR_W-1:0] reg_addr(input int unsigned i);
    case (i)
      R_CLO:   return A_CLO;
      R_CHI:   return A_CHI;
      R_MLO:   return A_MLO;
      R_MHI:   return A_MHI;
      R_INC:   return A_INC;
      default: return A_CTL;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] ws_addr(input int unsigned i);
    return (i <= R_CHI) ? A_CWS : A_GWS;
  endfunction

  function automatic int unsigned ws_bit(input int unsigned i);
    case (i)
      R_CLO:   return 0;
      R_CHI:   return 1;
      R_MLO:   return 0;
      R_MHI:   return 1;
      R_INC:   return 2;
      default: return B_WS_CTL;
    endcase
  endfunction
endpackage

// File: rtl/tmr64_apply_pipe.sv
module tmr64_apply_pipe #(
  parameter int unsigned DW  = 38,
  parameter int unsigned LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          vld_o,
  output logic [DW-1:0] dat_o
);
  logic [LAT-1:0] vld_q, vld_d;
  logic [DW-1:0]  dat_q [LAT];
  logic [DW-1:0]  dat_d [LAT];

  always_comb begin
    vld_d[0] = load;
    dat_d[0] = load ? din : dat_q[0];
    for (int i = 1; i < LAT; i++) begin
      vld_d[i] = vld_q[i-1];
      dat_d[i] = vld_q[i-1] ? dat_q[i-1] : dat_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < LAT; i++) dat_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < LAT; i++) dat_q[i] <= dat_d[i];
    end
  end

  assign vld_o = vld_q[LAT-1];
  assign dat_o = dat_q[LAT-1];
endmodule

// File: rtl/tmr64_counter.sv
module tmr64_counter #(
  parameter int unsigned CW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic [CW/2-1:0] ld_val,
  output logic [CW-1:0]   cnt_o
);
  localparam int unsigned HW = CW / 2;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_lo || ld_hi) begin
      if (ld_lo) cnt_d[HW-1:0]  = ld_val;
      if (ld_hi) cnt_d[CW-1:HW] = ld_val;
    end else if (run && tick) begin
      // full-width add: carry reaches the high half in the same cycle
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !ld_lo && !ld_hi) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && tick) && !ld_lo && !ld_hi) |=> $stable(cnt_q));
  a_r3_load_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (cnt_q[HW-1:0] == $past(ld_val)));
endmodule

// File: rtl/tmr64_compare.sv
module tmr64_compare #(
  parameter int unsigned CW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cnt_i,
  input  logic            cmp_en,
  input  logic            auto_en,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic            ld_inc,
  input  logic [CW/2-1:0] ld_val,
  input  logic            clr,
  output logic [CW-1:0]   cmp_o,
  output logic [CW/2-1:0] inc_o,
  output logic            flag_o
);
  localparam int unsigned HW = CW / 2;

  logic [CW-1:0] cmp_q, cmp_d;
  logic [HW-1:0] inc_q, inc_d;
  logic          flag_q, flag_d;
  logic          hit;

  assign hit = cmp_en && (cnt_i == cmp_q);

  always_comb begin
    cmp_d = cmp_q;
    if (ld_lo || ld_hi) begin
      if (ld_lo) cmp_d[HW-1:0]  = ld_val;
      if (ld_hi) cmp_d[CW-1:HW] = ld_val;
    end else if (hit && auto_en) begin
      cmp_d = cmp_q + CW'(inc_q);
    end
    inc_d  = ld_inc ? ld_val : inc_q;
    flag_d = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      inc_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      inc_q  <= inc_d;
      flag_q <= flag_d;
    end
  end

  assign cmp_o  = cmp_q;
  assign inc_o  = inc_q;
  assign flag_o = flag_q;

  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && (cnt_i == cmp_q)) |=> flag_q);
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && auto_en && (cnt_i == cmp_q) && !ld_lo && !ld_hi)
    |=> (cmp_q == $past(cmp_q) + CW'($past(inc_q))));
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cmp_en));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(cmp_en && (cnt_i == cmp_q))) |=> !flag_q);
endmodule

// File: rtl/tmr64_top.sv
module tmr64_top
  import tmr64_pkg::*;
#(
  parameter int unsigned APPLY_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int unsigned CW = 2 * DATA_W;
  localparam int unsigned PW = NREG + DATA_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic            wr_go;
  logic [NREG-1:0] wsel, ws_clr, ws_d, ws_q, ap;
  logic            p_vld;
  logic [PW-1:0]   p_dat;
  logic [DATA_W-1:0] ap_val;

  assign wr_go = bus_req && bus_wr;

  // one shared apply stage: the bus carries at most one write per cycle
  tmr64_apply_pipe #(.DW(PW), .LAT(APPLY_LAT)) u_apply (
    .clk   (clk),
    .rst_n (rst_i),
    .load  (|wsel),
    .din   ({wsel, bus_wdata}),
    .vld_o (p_vld),
    .dat_o (p_dat)
  );

  assign ap     = p_vld ? p_dat[PW-1 -: NREG] : '0;
  assign ap_val = p_dat[DATA_W-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_ws
    localparam logic [ADDR_W-1:0] RA = reg_addr(g);
    localparam logic [ADDR_W-1:0] SA = ws_addr(g);
    localparam int unsigned       SB = ws_bit(g);

    assign wsel[g]   = wr_go && (bus_addr == RA);
    assign ws_clr[g] = wr_go && (bus_addr == SA) && bus_wdata[SB];
    assign ws_d[g]   = ap[g] | (ws_q[g] & ~ws_clr[g]);

    a_r5_ws_set: assert property (@(posedge clk) disable iff (!rst_i)
      ap[g] |=> ws_q[g]);
  end

  // control, interrupt enable, status clear
  ctl_t ctl_q, ctl_d;
  logic ien_q, ien_d;
  logic ist_clr;

  assign ist_clr = wr_go && (bus_addr == A_IST) && bus_wdata[0];

  always_comb begin
    ctl_d = ctl_q;
    if (ap[R_CTL]) begin
      ctl_d.run     = ap_val[B_RUN];
      ctl_d.autoinc = ap_val[B_AUTO];
      ctl_d.cmp_en  = ap_val[B_CMPEN];
    end
    ien_d = (wr_go && (bus_addr == A_IEN)) ? bus_wdata[0] : ien_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_q <= '0;
      ien_q <= 1'b0;
      ws_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      ien_q <= ien_d;
      ws_q  <= ws_d;
    end
  end

  logic [CW-1:0]     cnt, cmp;
  logic [DATA_W-1:0] inc;
  logic              flag;

  tmr64_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_i),
    .run    (ctl_q.run),
    .tick   (tick_en),
    .ld_lo  (ap[R_CLO]),
    .ld_hi  (ap[R_CHI]),
    .ld_val (ap_val),
    .cnt_o  (cnt)
  );

  tmr64_compare #(.CW(CW)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_i),
    .cnt_i   (cnt),
    .cmp_en  (ctl_q.cmp_en),
    .auto_en (ctl_q.autoinc),
    .ld_lo   (ap[R_MLO]),
    .ld_hi   (ap[R_MHI]),
    .ld_inc  (ap[R_INC]),
    .ld_val  (ap_val),
    .clr     (ist_clr),
    .cmp_o   (cmp),
    .inc_o   (inc),
    .flag_o  (flag)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CLO: bus_rdata = cnt[DATA_W-1:0];
      A_CHI: bus_rdata = cnt[CW-1:DATA_W];
      A_CWS: begin
        bus_rdata[0] = ws_q[R_CLO];
        bus_rdata[1] = ws_q[R_CHI];
      end
      A_MLO: bus_rdata = cmp[DATA_W-1:0];
      A_MHI: bus_rdata = cmp[CW-1:DATA_W];
      A_INC: bus_rdata = inc;
      A_CTL: begin
        bus_rdata[B_RUN]   = ctl_q.run;
        bus_rdata[B_AUTO]  = ctl_q.autoinc;
        bus_rdata[B_CMPEN] = ctl_q.cmp_en;
      end
      A_IST: bus_rdata[0] = flag;
      A_IEN: bus_rdata[0] = ien_q;
      A_GWS: begin
        bus_rdata[0]        = ws_q[R_MLO];
        bus_rdata[1]        = ws_q[R_MHI];
        bus_rdata[2]        = ws_q[R_INC];
        bus_rdata[B_WS_CTL] = ws_q[R_CTL];
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flag & ien_q;

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_i)
    irq |-> ien_q);
  a_r5_one_apply: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(ap));
endmodule

// File: tb/tmr64_top_tb.sv
`timescale 1ns/100ps
module tmr64_top_tb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  tmr64_top #(.APPLY_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  bit done = 0;
  int tick_mode = 0;
  int phase = 0;
  int pidx = 0;

  // ---------------- reference model ----------------
  typedef struct { int due; int idx; logic [31:0] d; } pend_t;
  pend_t pq[$];
  int cyc = 0;
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_inc;
  logic m_run, m_auto, m_en, m_st, m_ie;
  logic [5:0] m_ws;

  function automatic int idx_of(input logic [11:0] a);
    case (a)
      12'h100: return 0;
      12'h104: return 1;
      12'h200: return 2;
      12'h204: return 3;
      12'h208: return 4;
      12'h240: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    logic [31:0] r = '0;
    case (a)
      12'h100: r = m_cnt[31:0];
      12'h104: r = m_cnt[63:32];
      12'h110: r = {30'b0, m_ws[1], m_ws[0]};
      12'h200: r = m_cmp[31:0];
      12'h204: r = m_cmp[63:32];
      12'h208: r = m_inc;
      12'h240: begin r[8] = m_run; r[1] = m_auto; r[0] = m_en; end
      12'h244: r[0] = m_st;
      12'h248: r[0] = m_ie;
      12'h24C: begin r[16] = m_ws[5]; r[2] = m_ws[4]; r[1] = m_ws[3]; r[0] = m_ws[2]; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h100, 12'h104, 12'h240: return "R2";
      12'h110, 12'h24C: return "R5";
      12'h200, 12'h204, 12'h244: return "R6";
      12'h208: return "R7";
      12'h248: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_cmp = '0; m_inc = '0;
      m_run = 0; m_auto = 0; m_en = 0; m_st = 0; m_ie = 0; m_ws = '0;
      pq.delete(); cyc = 0;
    end else begin
      bit [5:0] a;
      logic [31:0] v;
      bit hit, wr;
      logic [63:0] n_cnt, n_cmp;
      a = '0; v = '0;
      cyc++;
      if (pq.size() > 0 && pq[0].due == cyc) begin
        a[pq[0].idx] = 1'b1;
        v = pq[0].d;
        void'(pq.pop_front());
      end
      hit = m_en && (m_cnt == m_cmp);
      wr = bus_req && bus_wr;
      n_cnt = m_cnt;
      if (a[0] || a[1]) begin
        if (a[0]) n_cnt[31:0] = v;
        if (a[1]) n_cnt[63:32] = v;
      end else if (m_run && tick_en) n_cnt = m_cnt + 64'd1;
      n_cmp = m_cmp;
      if (a[2] || a[3]) begin
        if (a[2]) n_cmp[31:0] = v;
        if (a[3]) n_cmp[63:32] = v;
      end else if (hit && m_auto) n_cmp = m_cmp + {32'd0, m_inc};
      if (hit) m_st = 1'b1;
      else if (wr && bus_addr == 12'h244 && bus_wdata[0]) m_st = 1'b0;
      for (int i = 0; i < 6; i++) begin
        bit clr;
        case (i)
          0: clr = wr && bus_addr == 12'h110 && bus_wdata[0];
          1: clr = wr && bus_addr == 12'h110 && bus_wdata[1];
          2: clr = wr && bus_addr == 12'h24C && bus_wdata[0];
          3: clr = wr && bus_addr == 12'h24C && bus_wdata[1];
          4: clr = wr && bus_addr == 12'h24C && bus_wdata[2];
          default: clr = wr && bus_addr == 12'h24C && bus_wdata[16];
        endcase
        if (a[i]) m_ws[i] = 1'b1;
        else if (clr) m_ws[i] = 1'b0;
      end
      if (a[4]) m_inc = v;
      if (a[5]) begin m_run = v[8]; m_auto = v[1]; m_en = v[0]; end
      if (wr && bus_addr == 12'h248) m_ie = bus_wdata[0];
      m_cnt = n_cnt;
      m_cmp = n_cmp;
      if (wr && idx_of(bus_addr) >= 0) begin
        pend_t p;
        p.due = cyc + LAT; p.idx = idx_of(bus_addr); p.d = bus_wdata;
        pq.push_back(p);
      end
    end
  end

  // every-cycle comparison through the normal read port
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_chk++;
      if (bus_rdata !== mread(bus_addr)) begin
        n_fail++;
        $display("FAIL %s cycle read @%h actual=%h expected=%h", tag_of(bus_addr),
                 bus_addr, bus_rdata, mread(bus_addr));
      end
      n_chk++;
      if (irq !== (m_st & m_ie)) begin
        n_fail++;
        $display("FAIL R8 cycle irq actual=%b expected=%b", irq, m_st & m_ie);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [11:0] probe(input int i);
    case (i % 12)
      0: return 12'h100;  1: return 12'h104;  2: return 12'h110;
      3: return 12'h200;  4: return 12'h204;  5: return 12'h208;
      6: return 12'h240;  7: return 12'h244;  8: return 12'h248;
      9: return 12'h24C; 10: return 12'h0F0;  default: return 12'h3FC;
    endcase
  endfunction

  task automatic step(input logic r, input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    #1;
    tick_en   = (tick_mode == 1) || (tick_mode == 2 && (phase % 3 == 0));
    phase++;
    bus_req   = r;
    bus_wr    = w;
    bus_addr  = a;
    bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step(0, 0, probe(pidx), 32'd0);
      pidx++;
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    step(1, 1, a, d);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    step(0, 0, a, 32'd0);
    #0.5;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    step(0, 0, 12'h000, 32'd0);
    #0.5;
    chk(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      report();
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    idle(4);

    // R1 reset state
    chk_rd("R1 count low", 12'h100, 32'h0);
    chk_rd("R1 control", 12'h240, 32'h0);
    chk_rd("R1 write status", 12'h24C, 32'h0);
    chk_irq("R1 irq", 1'b0);

    // R9 unmapped offsets
    chk_rd("R9 unmapped 0x000", 12'h000, 32'h0);
    chk_rd("R9 unmapped 0x10C", 12'h10C, 32'h0);
    chk_rd("R9 unmapped 0x3FC", 12'h3FC, 32'h0);

    // R5 control write latency
    bwr(12'h240, 32'h0000_0100);
    idle(2);
    chk_rd("R5 not yet applied", 12'h24C, 32'h0);
    chk_rd("R5 applied flag", 12'h24C, 32'h0001_0000);
    chk_rd("R2 run bit", 12'h240, 32'h0000_0100);
    bwr(12'h24C, 32'h0001_0000);
    chk_rd("R5 cleared", 12'h24C, 32'h0);

    // R3 preload with counter idle
    bwr(12'h100, 32'hFFFF_FFFE);
    bwr(12'h104, 32'd7);
    idle(3);
    chk_rd("R3 preload low", 12'h100, 32'hFFFF_FFFE);
    chk_rd("R3 preload high", 12'h104, 32'd7);

    // R4 carry into high half
    tick_mode = 1; idle(3); tick_mode = 0;
    chk_rd("R4 high after rollover", 12'h104, 32'd8);
    chk_rd("R4 low after rollover", 12'h100, 32'd1);

    // R2 full wrap
    bwr(12'h100, 32'hFFFF_FFFF);
    bwr(12'h104, 32'hFFFF_FFFF);
    idle(3);
    tick_mode = 1; idle(1); tick_mode = 0;
    chk_rd("R2 wrap low", 12'h100, 32'h0);
    chk_rd("R2 wrap high", 12'h104, 32'h0);

    // R2 sparse ticks
    tick_mode = 2; idle(9); tick_mode = 0;
    chk_rd("R2 sparse ticks", 12'h100, 32'd3);

    // R3 write wins over increment
    tick_mode = 1;
    bwr(12'h100, 32'd100);
    bwr(12'h104, 32'd0);
    idle(3);
    tick_mode = 0;
    chk_rd("R3 load beats tick low", 12'h100, 32'd100);
    chk_rd("R3 load beats tick high", 12'h104, 32'd0);

    bwr(12'h110, 32'h3);
    bwr(12'h24C, 32'h0001_0007);

    // R6 / R8 match with a parked counter
    bwr(12'h200, 32'd100);
    bwr(12'h204, 32'd0);
    bwr(12'h248, 32'd1);
    bwr(12'h240, 32'h0000_0101);
    idle(4);
    chk_rd("R6 match status", 12'h244, 32'd1);
    chk_irq("R8 irq on", 1'b1);
    bwr(12'h244, 32'd1);
    chk_rd("R8 match beats clear", 12'h244, 32'd1);
    tick_mode = 1; idle(2); tick_mode = 0;
    bwr(12'h244, 32'd1);
    chk_rd("R8 clear", 12'h244, 32'd0);
    chk_irq("R8 irq off", 1'b0);

    // R10 comparator disabled
    bwr(12'h240, 32'h0000_0100);
    idle(3);
    bwr(12'h100, 32'd100);
    idle(4);
    chk_rd("R10 no status when disabled", 12'h244, 32'd0);
    chk_irq("R10 irq stays low", 1'b0);

    // R9 reserved control bits, R7 auto-rearm
    bwr(12'h240, 32'hFFFF_FFFF);
    idle(3);
    chk_rd("R9 control reserved bits", 12'h240, 32'h0000_0103);
    bwr(12'h208, 32'd10);
    bwr(12'h200, 32'd5);
    bwr(12'h100, 32'd0);
    idle(4);
    tick_mode = 1; idle(12); tick_mode = 0;
    chk_rd("R7 rearmed once", 12'h200, 32'd15);
    chk_rd("R7 count", 12'h100, 32'd12);
    tick_mode = 1; idle(10); tick_mode = 0;
    chk_rd("R7 rearmed twice", 12'h200, 32'd25);

    // R8 enable gates irq
    bwr(12'h248, 32'd0);
    chk_irq("R8 irq gated", 1'b0);
    chk_rd("R6 status kept", 12'h244, 32'd1);

    // R5 set wins over clear in the same cycle
    bwr(12'h110, 32'h3);
    bwr(12'h100, 32'd7);
    idle(2);
    bwr(12'h110, 32'h1);
    chk_rd("R5 set beats clear", 12'h110, 32'h1);
    bwr(12'h110, 32'h1);
    chk_rd("R5 clear after", 12'h110, 32'h0);

    idle(4);
    done = 1;
    report();
    $finish;
  end
endmodule